// File: doc/BRIEF.md
# Piecewise Linear Branch Predictor

This block predicts the direction of conditional branches. A single weight store holds one small signed integer for each combination of three things: the low bits of the branch being predicted, the low bits of a branch that came before it on the recent path, and that earlier branch's distance back in the history. A prediction adds one weight per history position to a per-branch bias. The weight is added when the earlier branch was taken and subtracted when it was not. A sum of zero or more means taken. Each distinct path into a branch therefore picks its own linear function, and all of those functions together form a piecewise linear decision surface.

A fetch stage presents a branch address on the prediction port and gets the direction and the signed sum one clock later. When the branch resolves, the back end returns the address, the real outcome and the sum it was given. Training runs when the direction was wrong or the sum was not yet confident. In the same edge the outcome and the address enter the global outcome history and the path address history. Only one branch is expected in flight between its prediction and its update. The histories move only on updates, so training sees exactly the history that was used for the prediction.

Two parameter choices reduce the block to older neural predictors. If the path index has one value (M = 1), every branch owns one weight vector, which is a perceptron predictor. If the branch index has one value (N = 1), all branches share weights chosen by the path alone, which is a path-based neural predictor.

Top module: `plp_predictor`

## Requirements
- R1: A synchronous reset sets every weight, both histories, pred_sum and pred_taken to zero. The first prediction after reset therefore gives sum 0.
- R2: The sum is the bias weight at [pc mod N, pc mod M, 0] plus, for each position i from 1 to H, ±weight[pc mod N, path_i mod M, i]. The sign is + when history bit i is 1 (taken) and − when it is 0.
- R3: pred_taken is 1 exactly when pred_sum ≥ 0. This includes a sum of exactly 0.
- R4: Weights are 8-bit signed and saturate at +127 and −128 without wrapping. With H = 4 a fully taken, saturated path gives +635 and a fully not-taken one gives −636.
- R5: An update trains only if the direction implied by upd_sum (taken when ≥ 0) differs from upd_taken, or if |upd_sum| ≤ theta. Theta is the integer part of 2.14·(H+1)+20.58, which is 31 for H = 4. Training moves the bias one step toward the outcome. It moves each position weight up when its history bit equals the outcome and down otherwise.
- R6: Every update shifts the outcome into history position 1 and the address (mod M) into path position 1. Older entries move one position back. Without an update the histories are unchanged.
- R7: With M = 1 the block gives the sums of a perceptron predictor, in which each branch address mod N owns one weight vector over history positions.
- R8: With N = 1 the block gives the sums of a path-based neural predictor, in which weights are shared by all branches and chosen by path address and position.
- R9: Only the low address bits (mod N and mod M, with N and M powers of two) affect the result. Addresses that differ only above those bits give identical predictions.
- R10: A prediction appears on pred_sum and pred_taken one clock after pred_en. While pred_en is low both outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_en | input | 1 | Request a prediction for pred_pc |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_sum | output | SUM_W | Signed sum behind the prediction |
| upd_en | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_sum | input | SUM_W | Sum that was returned when this branch was predicted |

## Verification
On every cycle the assertions check four things. Weights change only in a training cycle, and they never wrap at either end. The newest history and path entries always equal the last update's outcome and column, and the histories hold when no update occurs. The prediction outputs hold without a request and are zero right after reset. The scenarios alone can show whether the sums are numerically right for a given path, because that needs an independent model. The same applies to the exact threshold boundary (31 trains, 32 does not), the saturated totals, the equivalence of the M = 1 and N = 1 variants with their reduced models, and the aliasing of high address bits.

// File: rtl/plp_pkg.sv
package plp_pkg;

  typedef logic signed [7:0] wgt_t;

  localparam int WGT_MAX = 127;
  localparam int WGT_MIN = -128;

  // one saturating step toward up (1) or down (0)
  function automatic wgt_t wgt_step(input wgt_t w, input logic up);
    if (up) return (w == wgt_t'(WGT_MAX)) ? w : w + 8'sd1;
    else    return (w == wgt_t'(WGT_MIN)) ? w : w - 8'sd1;
  endfunction

  // truncated 2.14*(h+1)+20.58 in integer arithmetic
  function automatic int theta_of(input int h);
    return (214 * (h + 1) + 2058) / 100;
  endfunction

  // enough bits for (h+1) terms of magnitude 128 plus sign and margin
  function automatic int sum_width(input int h);
    return $clog2((h + 1) * 128) + 2;
  endfunction

endpackage

// File: rtl/plp_history.sv
module plp_history #(
  parameter int H  = 4,
  parameter int CW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift,
  input  logic                 in_taken,
  input  logic [CW-1:0]        in_col,
  output logic [H:1]           ghr,
  output logic [H:1][CW-1:0]   ga
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ghr <= '0;
      ga  <= '0;
    end else if (shift) begin
      for (int i = H; i >= 2; i--) begin
        ghr[i] <= ghr[i-1];
        ga[i]  <= ga[i-1];
      end
      ghr[1] <= in_taken;
      ga[1]  <= in_col;
    end
  end

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shift |=> (ghr[1] == $past(in_taken)) && (ga[1] == $past(in_col)));

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(ghr) && $stable(ga));

endmodule

// File: rtl/plp_weights.sv
module plp_weights
  import plp_pkg::*;
#(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int H  = 4,
  parameter int RW = 2,
  parameter int CW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RW-1:0]      rd_row,
  input  logic [H:0][CW-1:0] rd_col,
  output logic [H:0][7:0]    rd_w,
  input  logic               tr_en,
  input  logic [RW-1:0]      tr_row,
  input  logic [H:0][CW-1:0] tr_col,
  input  logic [H:0]         tr_up
);

  localparam int DEPTH = N * M * (H + 1);

  wgt_t mem [DEPTH];

  function automatic int slot(input int r, input int c, input int i);
    return (r * M + c) * (H + 1) + i;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (tr_en) begin
      for (int i = 0; i <= H; i++) begin
        mem[slot(int'(tr_row), int'(tr_col[i]), i)] <=
          wgt_step(mem[slot(int'(tr_row), int'(tr_col[i]), i)], tr_up[i]);
      end
    end
  end

  always_comb begin
    for (int i = 0; i <= H; i++)
      rd_w[i] = mem[slot(int'(rd_row), int'(rd_col[i]), i)];
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_chk
    // R5
    w_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !tr_en |=> $stable(mem[k]));
    // R4
    w_nowrap_hi_chk: assert property (@(posedge clk) disable iff (rst)
      (mem[k] == 8'sd127) |=> (mem[k] >= 8'sd126));
    // R4
    w_nowrap_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (mem[k] == -8'sd128) |=> (mem[k] <= -8'sd127));
  end

endmodule

// File: rtl/plp_dot.sv
module plp_dot #(
  parameter int H  = 4,
  parameter int SW = 12
) (
  input  logic [H:0][7:0]     w,
  input  logic [H:1]          hist,
  output logic signed [SW-1:0] sum
);

  function automatic logic signed [SW-1:0] term(input logic [7:0] wv,
                                                input logic plus);
    logic signed [SW-1:0] ext;
    ext = SW'($signed(wv));
    return plus ? ext : -ext;
  endfunction

  always_comb begin
    sum = term(w[0], 1'b1);
    for (int i = 1; i <= H; i++)
      sum = sum + term(w[i], hist[i]);
  end

endmodule

// File: rtl/plp_predictor.sv
module plp_predictor #(
  parameter int N    = 4,
  parameter int M    = 4,
  parameter int H    = 4,
  parameter int PC_W = 16,
  localparam int SUM_W = plp_pkg::sum_width(H)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pred_en,
  input  logic [PC_W-1:0]         pred_pc,
  output logic                    pred_taken,
  output logic signed [SUM_W-1:0] pred_sum,
  input  logic                    upd_en,
  input  logic [PC_W-1:0]         upd_pc,
  input  logic                    upd_taken,
  input  logic signed [SUM_W-1:0] upd_sum
);

  localparam int RW    = (N > 1) ? $clog2(N) : 1;
  localparam int CW    = (M > 1) ? $clog2(M) : 1;
  localparam int THETA = plp_pkg::theta_of(H);

  function automatic logic [RW-1:0] row_of(input logic [PC_W-1:0] pc);
    return RW'(pc & PC_W'(N - 1));
  endfunction

  function automatic logic [CW-1:0] col_of(input logic [PC_W-1:0] pc);
    return CW'(pc & PC_W'(M - 1));
  endfunction

  // history
  logic [H:1]          ghr;
  logic [H:1][CW-1:0]  ga;

  // weight store ports
  logic [RW-1:0]       rd_row, tr_row;
  logic [H:0][CW-1:0]  rd_col, tr_col;
  logic [H:0][7:0]     rd_w;
  logic [H:0]          tr_up;

  // training decision
  logic                    upd_agree;
  logic                    upd_weak;
  logic signed [SUM_W-1:0] upd_mag;
  logic                    train_en;
  logic signed [SUM_W-1:0] dot_sum;

  always_comb begin
    rd_row    = row_of(pred_pc);
    rd_col[0] = col_of(pred_pc);
    tr_row    = row_of(upd_pc);
    tr_col[0] = col_of(upd_pc);
    tr_up[0]  = upd_taken;
    for (int i = 1; i <= H; i++) begin
      rd_col[i] = ga[i];
      tr_col[i] = ga[i];
      tr_up[i]  = (ghr[i] == upd_taken);
    end
  end

  always_comb begin
    upd_agree = ((upd_sum >= 0) == upd_taken);
    upd_mag   = (upd_sum < 0) ? -upd_sum : upd_sum;
    upd_weak  = (upd_mag <= SUM_W'(THETA));
    train_en  = upd_en && (!upd_agree || upd_weak);
  end

  plp_history #(.H(H), .CW(CW)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift    (upd_en),
    .in_taken (upd_taken),
    .in_col   (col_of(upd_pc)),
    .ghr      (ghr),
    .ga       (ga)
  );

  plp_weights #(.N(N), .M(M), .H(H), .RW(RW), .CW(CW)) u_wgt (
    .clk    (clk),
    .rst    (rst),
    .rd_row (rd_row),
    .rd_col (rd_col),
    .rd_w   (rd_w),
    .tr_en  (train_en),
    .tr_row (tr_row),
    .tr_col (tr_col),
    .tr_up  (tr_up)
  );

  plp_dot #(.H(H), .SW(SUM_W)) u_dot (
    .w    (rd_w),
    .hist (ghr),
    .sum  (dot_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_sum   <= '0;
      pred_taken <= 1'b0;
    end else if (pred_en) begin
      pred_sum   <= dot_sum;
      pred_taken <= !dot_sum[SUM_W-1];
    end
  end

  // R10
  pred_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_en |=> $stable(pred_sum) && $stable(pred_taken));

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pred_sum == '0) && !pred_taken);

endmodule

// File: tb/test_plp_predictor.sv
`timescale 1ns/1ps
module test_plp_predictor;

  localparam int PW = 16;
  localparam int SW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          pred_en = 1'b0;
  logic [PW-1:0] pred_pc = '0;
  logic          upd_en = 1'b0;
  logic [PW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;
  logic signed [SW-1:0] us [3];
  logic                 pt [3];
  logic signed [SW-1:0] ps [3];

  // 0: N=4 M=4, 1: N=4 M=1 (perceptron), 2: N=1 M=4 (path-based)
  plp_predictor #(.N(4), .M(4), .H(4), .PC_W(PW)) i_plp_predictor (
    .clk(clk), .rst(rst), .pred_en(pred_en), .pred_pc(pred_pc),
    .pred_taken(pt[0]), .pred_sum(ps[0]), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_sum(us[0]));
  plp_predictor #(.N(4), .M(1), .H(4), .PC_W(PW)) i_plp_predictor_perc (
    .clk(clk), .rst(rst), .pred_en(pred_en), .pred_pc(pred_pc),
    .pred_taken(pt[1]), .pred_sum(ps[1]), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_sum(us[1]));
  plp_predictor #(.N(1), .M(4), .H(4), .PC_W(PW)) i_plp_predictor_path (
    .clk(clk), .rst(rst), .pred_en(pred_en), .pred_pc(pred_pc),
    .pred_taken(pt[2]), .pred_sum(ps[2]), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_sum(us[2]));

  int nchecks = 0;
  int nerrs = 0;

  // reference model
  int mw [3][4][4][5];
  bit mg [3][5];
  int ma [3][5];
  int nmask [3] = '{3, 3, 0};
  int mmask [3] = '{3, 0, 3};
  string rtag [3] = '{"R2", "R7", "R8"};

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrs++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 3; k++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          for (int i = 0; i < 5; i++) mw[k][r][c][i] = 0;
      for (int i = 0; i < 5; i++) begin mg[k][i] = 0; ma[k][i] = 0; end
    end
  endtask

  function automatic int msum(input int k, input int pc);
    int r, s;
    r = pc & nmask[k];
    s = mw[k][r][pc & mmask[k]][0];
    for (int i = 1; i <= 4; i++)
      s += mg[k][i] ? mw[k][r][ma[k][i]][i] : -mw[k][r][ma[k][i]][i];
    return s;
  endfunction

  task automatic mtrain(input int k, input int pc, input bit tk, input int s);
    int r, mag;
    bit dir;
    r = pc & nmask[k];
    dir = (s >= 0);
    mag = (s < 0) ? -s : s;
    if (dir != tk || mag <= 31) begin
      mw[k][r][pc & mmask[k]][0] = sat8(mw[k][r][pc & mmask[k]][0] + (tk ? 1 : -1));
      for (int i = 1; i <= 4; i++)
        mw[k][r][ma[k][i]][i] = sat8(mw[k][r][ma[k][i]][i] + ((mg[k][i] == tk) ? 1 : -1));
    end
    for (int i = 4; i >= 2; i--) begin mg[k][i] = mg[k][i-1]; ma[k][i] = ma[k][i-1]; end
    mg[k][1] = tk;
    ma[k][1] = pc & mmask[k];
  endtask

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst = 1'b1; pred_en = 1'b0; upd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic predict(input int pc);
    pred_pc = PW'(pc); pred_en = 1'b1;
    @(negedge clk);
    pred_en = 1'b0;
  endtask

  task automatic train(input int pc, input bit tk, input bit forced, input int fv);
    upd_pc = PW'(pc); upd_taken = tk;
    for (int k = 0; k < 3; k++) us[k] = forced ? SW'(fv) : ps[k];
    upd_en = 1'b1;
    @(negedge clk);
    upd_en = 1'b0;
    for (int k = 0; k < 3; k++) mtrain(k, pc, tk, int'(us[k]));
  endtask

  task automatic branch(input int pc, input bit tk, input bit forced, input int fv,
                        input bit cmp);
    predict(pc);
    if (cmp) begin
      for (int k = 0; k < 3; k++) begin
        chk(rtag[k], "sum", int'(ps[k]), msum(k, pc));
        chk("R3", "taken", int'(pt[k]), (msum(k, pc) >= 0) ? 1 : 0);
      end
    end
    train(pc, tk, forced, fv);
  endtask

  task automatic t_reset_state();
    do_reset();
    for (int k = 0; k < 3; k++) begin
      chk("R1", "sum after reset", int'(ps[k]), 0);
      chk("R1", "taken after reset", int'(pt[k]), 0);
    end
    predict(5);
    chk("R1", "first sum", int'(ps[0]), 0);
    chk("R3", "zero sum taken", int'(pt[0]), 1);
  endtask

  task automatic t_first_path();
    do_reset();
    branch(6, 1'b1, 1'b0, 0, 1'b1);
    predict(6);
    chk("R6", "sum after one shift", int'(ps[0]), 4);
    chk("R7", "perceptron sum after one shift", int'(ps[1]), 3);
    chk("R8", "path sum after one shift", int'(ps[2]), 4);
  endtask

  task automatic t_patterns();
    do_reset();
    for (int j = 0; j < 80; j++)
      branch(((j * 37) ^ (j << 6)) & 16'hFFFF, ((j * j) % 5) < 3, 1'b0, 0, 1'b1);
    for (int j = 0; j < 60; j++)
      branch(10 + (j % 3), (j % 3) != 2, 1'b0, 0, 1'b1);
    for (int j = 0; j < 40; j++)
      branch((j % 2) ? 5 : 12, (j % 4) < 2, 1'b0, 0, 1'b1);
  endtask

  task automatic t_alias();
    int s0, s1, s2;
    predict(3);
    s0 = int'(ps[0]); s1 = int'(ps[1]); s2 = int'(ps[2]);
    predict(3 + 16);
    chk("R9", "alias +16", int'(ps[0]), s0);
    predict(3 + 16'h4A0);
    chk("R9", "alias high bits", int'(ps[0]), s0);
    chk("R9", "alias high bits m1", int'(ps[1]), s1);
    chk("R9", "alias high bits n1", int'(ps[2]), s2);
  endtask

  task automatic t_hold();
    int s;
    predict(11);
    s = int'(ps[0]);
    chk("R10", "one-cycle result", s, msum(0, 11));
    pred_pc = PW'(5);
    repeat (3) @(negedge clk);
    chk("R10", "hold sum", int'(ps[0]), s);
    chk("R10", "hold taken", int'(pt[0]), (s >= 0) ? 1 : 0);
  endtask

  task automatic t_sat_hi();
    do_reset();
    for (int j = 0; j < 150; j++) branch(9, 1'b1, 1'b1, -1, 1'b0);
    predict(9);
    chk("R4", "saturated taken sum", int'(ps[0]), 635);
    chk("R3", "saturated taken dir", int'(pt[0]), 1);
  endtask

  task automatic t_sat_lo();
    do_reset();
    for (int j = 0; j < 300; j++) branch(9, 1'b0, 1'b1, 0, 1'b0);
    predict(9);
    chk("R4", "saturated not-taken sum", int'(ps[0]), -636);
    chk("R3", "saturated not-taken dir", int'(pt[0]), 0);
  endtask

  task automatic t_thresh();
    do_reset();
    for (int j = 0; j < 12; j++) branch(9, 1'b1, 1'b1, -1, 1'b0);
    predict(9);
    chk("R5", "trained sum", int'(ps[0]), 50);
    train(9, 1'b1, 1'b1, 50);
    predict(9);
    chk("R5", "confident skip", int'(ps[0]), 50);
    train(9, 1'b1, 1'b1, 31);
    predict(9);
    chk("R5", "at theta trains", int'(ps[0]), 55);
    train(9, 1'b1, 1'b1, 32);
    predict(9);
    chk("R5", "above theta skips", int'(ps[0]), 55);
    train(9, 1'b1, 1'b1, -100);
    predict(9);
    chk("R5", "strong mispredict trains", int'(ps[0]), 60);
  endtask

  task automatic t_reset_mid();
    do_reset();
    predict(9);
    chk("R1", "weights cleared", int'(ps[0]), 0);
    chk("R1", "weights cleared n1", int'(ps[2]), 0);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) us[k] = '0;
    t_reset_state();
    t_first_path();
    t_patterns();
    t_alias();
    t_hold();
    t_sat_hi();
    t_sat_lo();
    t_thresh();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++;
    nerrs++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
    $finish;
  end

endmodule